// File: doc/BRIEF.md
# Cascadable Serial Configuration Bit-Stream Reader

This block is the read side of a serial memory that feeds a configuration bit-stream to a programmable logic device, one bit per clock. It holds a bit array with a parameterised depth and an address pointer. It presents the bit under the pointer on a data output that has a separate drive-enable flag, so no real tri-state net is needed. The pointer moves to the next bit on each rising clock edge while the device is selected and running.

A reset/output-enable input clears the pointer and stops the output driver. Its active level is chosen at build time. A low chip-select makes the device supply bits, and a high chip-select puts it in standby. A low serial-enable input selects a programming mode, which suspends readout and opens a simple synchronous write port for preloading the array.

Once the last stored bit has been taken, the device stops driving and pulls its cascade output low. When that cascade output drives the chip-select of a second device, the second device continues the stream with no gap and no overlap.

Top module: `cfgrd_reader`

## Requirements
- R1: The reset input's active level is set by parameter RST_POL (RST_POL_HIGH by default, active level 1; RST_POL_LOW gives active level 0). While the reset input is active, the next clock edge clears the pointer to bit 0. During that time data_oe is 0 and ceo_n is 1.
- R2: While ce_n is 0, ser_en is 1, reset is inactive and the last bit has not been consumed, data_oe is 1 and data_out equals the stored bit at the pointer. The stream starts with bit 0, and each rising clock edge advances the pointer by exactly one.
- R3: The rising edge that consumes bit DEPTH-1 drives ceo_n to 0 and data_oe to 0. Both stay at those values until the reset input becomes active.
- R4: While ce_n is 1, data_oe is 0 and the pointer holds its value. When ce_n returns to 0, the stream resumes at the same bit.
- R5: While ser_en is 0, data_oe is 0 and the pointer holds. A write with wr_en=1 stores wr_data at wr_addr on a rising edge. A write attempted while ser_en is 1 leaves the array unchanged.
- R6: While the reset input stays inactive, a device that has finished stays finished: ceo_n stays 0 and the pointer does not wrap back to bit 0.
- R7: In a chain where the first device's ceo_n drives the second device's ce_n, exactly one device drives in each bit slot until both are finished. The combined stream is the first array followed directly by the second array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; the pointer advances on the rising edge |
| ce_n | input | 1 | Chip select, active low; high selects standby |
| rst_oe | input | 1 | Reset/output-enable; active level set by RST_POL |
| ser_en | input | 1 | High for readout, low for programming mode |
| wr_en | input | 1 | Write strobe for the preload port; acts only in programming mode |
| wr_addr | input | AW | Bit index written by the preload port |
| wr_data | input | 1 | Bit value written by the preload port |
| data_out | output | 1 | Serial data value; 0 when not driven |
| data_oe | output | 1 | Drive enable of the data output |
| ceo_n | output | 1 | Cascade output, active low; drops after the last bit |

## Verification
The bench builds two devices with different depths, 16 and 12, and opposite reset polarities. It chains them, so that both polarity variants of the generate branch and a depth that is not a power of two are exercised in one run. With these small depths, every address of both arrays is streamed and compared against arithmetic patterns computed in the bench. The run also covers the handoff slot, a standby pause inside the first array and a programming pause inside the second. It then resets only the first device, which shows that the second device keeps its finished state while its own reset stays inactive.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;
   typedef enum logic {
      RST_POL_LOW  = 1'b0,
      RST_POL_HIGH = 1'b1
   } rst_pol_e;
endpackage

// File: rtl/cfgrd_mode.sv
module cfgrd_mode
   import cfgrd_pkg::*;
#(
   parameter rst_pol_e RST_POL = RST_POL_HIGH
) (
   input  logic rst_oe,
   input  logic ce_n,
   input  logic ser_en,
   input  logic done,
   output logic clr,
   output logic active,
   output logic prog
);
   generate
      if (RST_POL == RST_POL_HIGH) begin : g_rst_high
         assign clr = rst_oe;
      end else begin : g_rst_low
         assign clr = ~rst_oe;
      end
   endgenerate

   assign prog   = ~ser_en;
   assign active = ~ce_n & ser_en & ~clr & ~done;
endmodule

// File: rtl/cfgrd_bits.sv
module cfgrd_bits #(
   parameter int DEPTH = 64,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic          wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic          rd_bit
);
   logic [DEPTH-1:0] cells;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_cell
         always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == AW'(i))) cells[i] <= wr_data;
         end
      end
   endgenerate

   assign rd_bit = (int'(rd_addr) < DEPTH) ? cells[rd_addr] : 1'b0;
endmodule

// File: rtl/cfgrd_seq.sv
module cfgrd_seq #(
   parameter int DEPTH = 64,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          active,
   output logic [AW-1:0] addr,
   output logic          done
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   always_ff @(posedge clk) begin
      if (clr) begin
         addr <= '0;
         done <= 1'b0;
      end else if (active) begin
         if (addr == LAST) done <= 1'b1;
         else              addr <= addr + 1'b1;
      end
   end

   assert_clear_R1: assert property (@(posedge clk)
      clr |=> (addr == '0 && !done));
   assert_step_R2: assert property (@(posedge clk) disable iff (clr)
      (active && addr != LAST) |=> (addr == AW'($past(addr) + 1'b1)));
   assert_terminal_R3: assert property (@(posedge clk) disable iff (clr)
      (active && addr == LAST) |=> done);
   assert_stay_done_R6: assert property (@(posedge clk) disable iff (clr)
      done |=> (done && $stable(addr)));
   assert_hold_R4: assert property (@(posedge clk) disable iff (clr)
      !active |=> $stable(addr));
endmodule

// File: rtl/cfgrd_reader.sv
module cfgrd_reader
   import cfgrd_pkg::*;
#(
   parameter int       DEPTH   = 64,
   parameter rst_pol_e RST_POL = RST_POL_HIGH,
   localparam int      AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          ce_n,
   input  logic          rst_oe,
   input  logic          ser_en,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic          wr_data,
   output logic          data_out,
   output logic          data_oe,
   output logic          ceo_n
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("cfgrd_reader: DEPTH must be at least 2");
      end
   endgenerate

   logic          clr;
   logic          active;
   logic          prog;
   logic          done;
   logic [AW-1:0] addr;
   logic          rd_bit;

   cfgrd_mode #(.RST_POL(RST_POL)) i_mode (
      .rst_oe (rst_oe),
      .ce_n   (ce_n),
      .ser_en (ser_en),
      .done   (done),
      .clr    (clr),
      .active (active),
      .prog   (prog)
   );

   cfgrd_seq #(.DEPTH(DEPTH)) i_seq (
      .clk    (clk),
      .clr    (clr),
      .active (active),
      .addr   (addr),
      .done   (done)
   );

   cfgrd_bits #(.DEPTH(DEPTH)) i_bits (
      .clk     (clk),
      .wr_en   (wr_en & prog),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (addr),
      .rd_bit  (rd_bit)
   );

   assign data_oe  = active;
   assign data_out = active ? rd_bit : 1'b0;
   assign ceo_n    = ~done;

   assert_quiet_after_last_R3: assert property (@(posedge clk) disable iff (clr)
      !ceo_n |-> !data_oe);
   assert_prog_hold_R5: assert property (@(posedge clk) disable iff (clr)
      !ser_en |=> $stable(addr));
   assert_standby_hold_R4: assert property (@(posedge clk) disable iff (clr)
      ce_n |=> ($stable(addr) && $stable(ceo_n)));
endmodule

// File: tb/test_cfgrd_reader.sv
module test_cfgrd_reader;
   import cfgrd_pkg::*;

   localparam int DA  = 16;
   localparam int DB  = 12;
   localparam int AWA = $clog2(DA);
   localparam int AWB = $clog2(DB);
   localparam int N   = DA + DB;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic ce_n_a = 1'b0;
   logic rst_a = 1'b1;
   logic rst_b = 1'b0;
   logic sen_a = 1'b1;
   logic sen_b = 1'b1;
   logic wen_a = 1'b0;
   logic wen_b = 1'b0;
   logic [AWA-1:0] wad_a = '0;
   logic [AWB-1:0] wad_b = '0;
   logic wd_a = 1'b0;
   logic wd_b = 1'b0;
   logic d_a, oe_a, ceo_a, d_b, oe_b, ceo_b;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   cfgrd_reader #(.DEPTH(DA), .RST_POL(RST_POL_HIGH)) i_cfgrd_reader (
      .clk(clk), .ce_n(ce_n_a), .rst_oe(rst_a), .ser_en(sen_a),
      .wr_en(wen_a), .wr_addr(wad_a), .wr_data(wd_a),
      .data_out(d_a), .data_oe(oe_a), .ceo_n(ceo_a));

   cfgrd_reader #(.DEPTH(DB), .RST_POL(RST_POL_LOW)) i_cfgrd_reader_b (
      .clk(clk), .ce_n(ceo_a), .rst_oe(rst_b), .ser_en(sen_b),
      .wr_en(wen_b), .wr_addr(wad_b), .wr_data(wd_b),
      .data_out(d_b), .data_oe(oe_b), .ceo_n(ceo_b));

   function automatic bit a_bit(int i);
      return ((i * 7 + 3) % 5) < 2;
   endfunction

   function automatic bit b_bit(int i);
      return ((i * 5 + 1) % 3) == 0;
   endfunction

   function automatic bit exp_bit(int k);
      return (k < DA) ? a_bit(k) : b_bit(k - DA);
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      bad++;
      total++;
      $display("FAIL watchdog: actual=1 expected=0");
      finish_run();
   end

   initial begin
      bit pa;
      bit pb;
      int k;
      repeat (3) @(negedge clk);
      // R1: reset state, both polarities active
      chk(!oe_a && !oe_b, "R1 reset quiet", {oe_a, oe_b}, 0);
      chk(ceo_a && ceo_b, "R1 cascade high", {ceo_a, ceo_b}, 3);

      // R5: programming mode preload
      sen_a = 1'b0;
      sen_b = 1'b0;
      for (int i = 0; i < DA; i++) begin
         wen_a = 1'b1; wad_a = AWA'(i); wd_a = a_bit(i);
         if (i < DB) begin
            wen_b = 1'b1; wad_b = AWB'(i); wd_b = b_bit(i);
         end else wen_b = 1'b0;
         @(negedge clk);
         chk(!oe_a && !oe_b, "R5 no drive in programming", {oe_a, oe_b}, 0);
      end
      wen_a = 1'b0;
      wen_b = 1'b0;
      sen_a = 1'b1;
      sen_b = 1'b1;
      // R5: write attempt outside programming mode is ignored
      wen_a = 1'b1; wad_a = '0; wd_a = ~a_bit(0);
      @(negedge clk);
      wen_a = 1'b0;
      rst_a = 1'b0;
      rst_b = 1'b1;
      #1;

      // R2, R4, R5, R7: full chained stream
      pa = 1'b0;
      pb = 1'b0;
      k = 0;
      while (k < N) begin
         if (k == 5 && !pa) begin
            pa = 1'b1;
            ce_n_a = 1'b1;
            repeat (3) begin
               @(negedge clk);
               chk(!oe_a && !oe_b, "R4 standby quiet", {oe_a, oe_b}, 0);
            end
            ce_n_a = 1'b0;
            #1;
         end
         if (k == DA + 4 && !pb) begin
            pb = 1'b1;
            sen_b = 1'b0;
            repeat (2) begin
               @(negedge clk);
               chk(!oe_b && !oe_a, "R5 programming pause quiet", {oe_a, oe_b}, 0);
            end
            sen_b = 1'b1;
            #1;
         end
         chk(oe_a == (k < DA) && oe_b == (k >= DA), "R7 single driver",
             {oe_a, oe_b}, (k < DA) ? 2 : 1);
         chk((oe_a ? d_a : d_b) == exp_bit(k), (k < DA) ? "R2 stream bit" : "R7 stream bit",
             oe_a ? d_a : d_b, exp_bit(k));
         if (k == DA) chk(!ceo_a, "R3 first cascade low", ceo_a, 0);
         @(negedge clk);
         k++;
      end

      // R3: both finished
      chk(!ceo_a && !ceo_b, "R3 cascade low", {ceo_a, ceo_b}, 0);
      chk(!oe_a && !oe_b, "R3 released", {oe_a, oe_b}, 0);
      // R6: no wrap while reset inactive
      repeat (5) begin
         @(negedge clk);
         chk(!ceo_a && !ceo_b && !oe_a && !oe_b, "R6 stays finished",
             {ceo_a, ceo_b, oe_a, oe_b}, 0);
      end

      // R1 / R6: reset only the first device
      rst_a = 1'b1;
      @(negedge clk);
      chk(ceo_a && !oe_a, "R1 cleared", {ceo_a, oe_a}, 2);
      chk(!ceo_b && !oe_b, "R6 second stays finished", {ceo_b, oe_b}, 0);
      rst_a = 1'b0;
      #1;
      for (int i = 0; i < 4; i++) begin
         chk(oe_a && d_a == a_bit(i), (i == 0) ? "R5 ignored write" : "R1 restart",
             d_a, a_bit(i));
         @(negedge clk);
      end
      chk(!oe_b && !ceo_b, "R6 second quiet", {oe_b, ceo_b}, 0);
      finish_run();
   end
endmodule